// File: doc/BRIEF.md
# Lockable General-Purpose I/O Port

This block is the register file and pad control for one port of general-purpose pins, accessed over a simple single-cycle register bus. Each pin can be made an input, a software-driven output, an output owned by a peripheral through a 4-bit function selector, or an analog pin. Each pin also has a push-pull or open-drain type, a drive-speed code and a pull code. Software changes output bits through a data register, or atomically through a write-only set/clear register. Pad inputs reach a readable input register through a two-stage synchronizer.

A key sequence on the lock register freezes the configuration of a chosen set of pins until the next reset. Software writes the same pin mask three times with the key bit at 1, 0, 1 and then reads the lock register. After that, writes to the configuration fields of those pins are dropped. The output data stays writable.

Top module: `gpio_lock_port`

## Requirements
- R1: After reset every pin is a floating input: mode, pull, speed, type, output data and both function-select registers read 0, no pad is enabled and the lock register reads 0.
- R2: The mode code per pin is 2 bits at bits [2p+1:2p] of the mode register (word 0): 00 input, 01 output, 10 peripheral-owned, 11 analog. `pad_oe` can be high only in modes 01 and 10. `pad_analog` is high exactly in mode 11.
- R3: In mode 01 a pin drives the output data bit p (word 5). In mode 10 it drives `alt_drive_in[p]`. In modes 00 and 11 `pad_out` is 0.
- R4: The type bit p (word 1, 1 = open-drain) and the speed code (word 2, bits [2p+1:2p]) apply only in modes 01 and 10; elsewhere `pad_od` and `pad_speed` read 0. An open-drain pin enables its pad only while its value is 0.
- R5: The function selector of pin p is 4 bits at bit offset (p mod 8)*4. Pins 0..7 use word 8 and pins 8..15 use word 9. `alt_sel[4p+3:4p]` carries it.
- R6: In a write to word 6, bit n (n < 16) at 1 sets output bit n and bit n+16 at 1 clears it. Zero bits leave their output bit alone. If both bits are 1, the set wins. Word 6 reads 0.
- R7: Word 4 returns each pad input two clock edges after it changes, and returns 0 for pins in analog mode.
- R8: Word 7 holds the lock mask in bits [15:0] and the key bit in bit 16. Three writes with the same mask and key bits 1, 0, 1, followed by a read of word 7, arm the lock. The confirming read returns 0. Later reads return the key bit as 1 together with the mask.
- R9: During the sequence, a wrong key value, a changed mask or a write after the third step returns the sequence to its start, and nothing gets locked.
- R10: While the lock is armed, writes leave the mode, type, speed, pull and function-select fields of locked pins unchanged. Unlocked pins in the same write are updated, and the output data and set/clear registers keep working.
- R11: Once armed, the lock ignores further writes to word 7 and stays armed until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle as the read request |
| pad_in | input | 16 | Raw pad input levels |
| alt_drive_in | input | 16 | Output value from the selected peripheral, per pin |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output enable |
| pad_od | output | 16 | Open-drain type flag for driven pins |
| pad_pull | output | 32 | Pull code per pin |
| pad_speed | output | 32 | Drive-speed code per driven pin |
| pad_analog | output | 16 | Analog mode per pin |
| alt_sel | output | 64 | Function selector per pin |

## Verification
The bench builds the block with its default parameters: 16 pins, a 32-bit data path and a 4-bit address. With these values the two function-select words each hold exactly eight pins, so the pin 7/8 boundary is exercised. The set and clear halves of word 6 also fill the data word completely. The bench runs a mix of all four modes with open-drain pins driving both levels, and set/clear collisions on the same pin. Aborted key sequences are followed by a partial lock. Further lock attempts are made after arming, and a second reset clears the lock.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;

    typedef enum logic [1:0] {
        PM_INPUT  = 2'b00,
        PM_OUTPUT = 2'b01,
        PM_ALT    = 2'b10,
        PM_ANALOG = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        LK_IDLE,
        LK_FIRST,
        LK_SECOND,
        LK_CONFIRM
    } lock_step_e;

    localparam int unsigned REG_MODE   = 0;
    localparam int unsigned REG_OTYPE  = 1;
    localparam int unsigned REG_SPEED  = 2;
    localparam int unsigned REG_PULL   = 3;
    localparam int unsigned REG_IDATA  = 4;
    localparam int unsigned REG_ODATA  = 5;
    localparam int unsigned REG_SETCLR = 6;
    localparam int unsigned REG_LOCK   = 7;
    localparam int unsigned REG_AFLO   = 8;
    localparam int unsigned REG_AFHI   = 9;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.stage1 = raw_in;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.stage2;
endmodule

// File: rtl/gpio_key_lock.sv
module gpio_key_lock
    import gpio_lock_pkg::*;
#(
    parameter int unsigned PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            key_wr,
    input  logic            key_rd,
    input  logic            key_bit,
    input  logic [PINS-1:0] key_mask,
    output logic            lock_active,
    output logic [PINS-1:0] lock_mask
);
    typedef struct packed {
        lock_step_e      step;
        logic [PINS-1:0] seen;
        logic            active;
        logic [PINS-1:0] locked;
    } key_t;

    key_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (!k_q.active) begin
            if (key_wr) begin
                case (k_q.step)
                    LK_IDLE: begin
                        if (key_bit) begin
                            k_d.step = LK_FIRST;
                            k_d.seen = key_mask;
                        end
                    end
                    LK_FIRST:
                        k_d.step = (!key_bit && key_mask == k_q.seen) ? LK_SECOND : LK_IDLE;
                    LK_SECOND:
                        k_d.step = (key_bit && key_mask == k_q.seen) ? LK_CONFIRM : LK_IDLE;
                    default:
                        k_d.step = LK_IDLE;
                endcase
            end else if (key_rd && k_q.step == LK_CONFIRM) begin
                k_d.active = 1'b1;
                k_d.locked = k_q.seen;
                k_d.step   = LK_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '{step: LK_IDLE, seen: '0, active: 1'b0, locked: '0};
        else        k_q <= k_d;
    end

    assign lock_active = k_q.active;
    assign lock_mask   = k_q.locked;
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_lock_pkg::*;
#(
    parameter int unsigned PINS = 16
) (
    input  logic [2*PINS-1:0] mode,
    input  logic [PINS-1:0]   otype,
    input  logic [2*PINS-1:0] speed,
    input  logic [PINS-1:0]   odata,
    input  logic [PINS-1:0]   alt_val,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_od,
    output logic [PINS-1:0]   pad_analog,
    output logic [2*PINS-1:0] pad_speed
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin
        pin_mode_e pm;
        logic      drives;
        logic      value;

        assign pm     = pin_mode_e'(mode[2*p +: 2]);
        assign drives = (pm == PM_OUTPUT) || (pm == PM_ALT);
        assign value  = (pm == PM_ALT) ? alt_val[p] : odata[p];

        assign pad_out[p]        = drives & value;
        assign pad_od[p]         = drives & otype[p];
        assign pad_oe[p]         = drives & (~otype[p] | ~value);
        assign pad_analog[p]     = (pm == PM_ANALOG);
        assign pad_speed[2*p +: 2] = drives ? speed[2*p +: 2] : 2'b00;
    end
endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
    import gpio_lock_pkg::*;
#(
    parameter int unsigned PINS = 16,
    parameter int unsigned DW   = 32,
    parameter int unsigned AW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic [DW-1:0]     rsp_rdata,
    input  logic [PINS-1:0]   pad_in,
    input  logic [PINS-1:0]   alt_drive_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_od,
    output logic [2*PINS-1:0] pad_pull,
    output logic [2*PINS-1:0] pad_speed,
    output logic [PINS-1:0]   pad_analog,
    output logic [4*PINS-1:0] alt_sel
);
    localparam int unsigned F2W     = 2 * PINS;
    localparam int unsigned SELW    = 4;
    localparam int unsigned AFB     = SELW * PINS;
    localparam int unsigned KEY_BIT = PINS;

    typedef struct packed {
        logic [F2W-1:0]  mode;
        logic [PINS-1:0] otype;
        logic [F2W-1:0]  speed;
        logic [F2W-1:0]  pull;
        logic [DW-1:0]   af_lo;
        logic [DW-1:0]   af_hi;
        logic [PINS-1:0] odata;
    } cfg_t;

    cfg_t r_d, r_q;

    logic            wr_en, rd_en;
    logic            lock_active;
    logic [PINS-1:0] lock_mask;
    logic [PINS-1:0] lk;
    logic [F2W-1:0]  lk2;
    logic [AFB-1:0]  lk4;
    logic [PINS-1:0] in_sync;
    logic [PINS-1:0] set_bits, clr_bits;

    logic [F2W-1:0]  mode_w;
    logic [PINS-1:0] otype_w;
    logic [PINS-1:0] odata_w;

    assign wr_en    = req_valid &  req_write;
    assign rd_en    = req_valid & ~req_write;
    assign lk       = lock_active ? lock_mask : '0;
    assign set_bits = req_wdata[PINS-1:0];
    assign clr_bits = req_wdata[2*PINS-1:PINS];

    for (genvar p = 0; p < PINS; p++) begin : g_lk
        assign lk2[2*p +: 2]       = {2{lk[p]}};
        assign lk4[SELW*p +: SELW] = {SELW{lk[p]}};
    end

    gpio_in_sync #(.WIDTH(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pad_in),
        .sync_out (in_sync)
    );

    gpio_key_lock #(.PINS(PINS)) u_key (
        .clk         (clk),
        .rst_n       (rst_n),
        .key_wr      (wr_en && req_addr == AW'(REG_LOCK)),
        .key_rd      (rd_en && req_addr == AW'(REG_LOCK)),
        .key_bit     (req_wdata[KEY_BIT]),
        .key_mask    (req_wdata[PINS-1:0]),
        .lock_active (lock_active),
        .lock_mask   (lock_mask)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (req_addr)
                AW'(REG_MODE):   r_d.mode  = (r_q.mode  & lk2) | (req_wdata[F2W-1:0]  & ~lk2);
                AW'(REG_OTYPE):  r_d.otype = (r_q.otype & lk)  | (req_wdata[PINS-1:0] & ~lk);
                AW'(REG_SPEED):  r_d.speed = (r_q.speed & lk2) | (req_wdata[F2W-1:0]  & ~lk2);
                AW'(REG_PULL):   r_d.pull  = (r_q.pull  & lk2) | (req_wdata[F2W-1:0]  & ~lk2);
                AW'(REG_ODATA):  r_d.odata = req_wdata[PINS-1:0];
                AW'(REG_SETCLR): r_d.odata = (r_q.odata & ~clr_bits) | set_bits;
                AW'(REG_AFLO):   r_d.af_lo = (r_q.af_lo & lk4[DW-1:0])   | (req_wdata & ~lk4[DW-1:0]);
                AW'(REG_AFHI):   r_d.af_hi = (r_q.af_hi & lk4[AFB-1:DW]) | (req_wdata & ~lk4[AFB-1:DW]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rsp_rdata = '0;
        if (rd_en) begin
            case (req_addr)
                AW'(REG_MODE):  rsp_rdata[F2W-1:0]  = r_q.mode;
                AW'(REG_OTYPE): rsp_rdata[PINS-1:0] = r_q.otype;
                AW'(REG_SPEED): rsp_rdata[F2W-1:0]  = r_q.speed;
                AW'(REG_PULL):  rsp_rdata[F2W-1:0]  = r_q.pull;
                AW'(REG_IDATA): rsp_rdata[PINS-1:0] = in_sync & ~pad_analog;
                AW'(REG_ODATA): rsp_rdata[PINS-1:0] = r_q.odata;
                AW'(REG_LOCK):  rsp_rdata[KEY_BIT:0] = {lock_active, lk};
                AW'(REG_AFLO):  rsp_rdata = r_q.af_lo;
                AW'(REG_AFHI):  rsp_rdata = r_q.af_hi;
                default: ;
            endcase
        end
    end

    gpio_pin_drive #(.PINS(PINS)) u_drive (
        .mode       (r_q.mode),
        .otype      (r_q.otype),
        .speed      (r_q.speed),
        .odata      (r_q.odata),
        .alt_val    (alt_drive_in),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe),
        .pad_od     (pad_od),
        .pad_analog (pad_analog),
        .pad_speed  (pad_speed)
    );

    assign pad_pull = r_q.pull;
    assign alt_sel  = {r_q.af_hi, r_q.af_lo};
    assign mode_w   = r_q.mode;
    assign otype_w  = r_q.otype;
    assign odata_w  = r_q.odata;
endmodule

// File: rtl/gpio_lock_port_chk.sv
module gpio_lock_port_chk #(
    parameter int unsigned PINS = 16,
    parameter int unsigned AW   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [AW-1:0]     req_addr,
    input logic [PINS-1:0]   wr_low,
    input logic [2*PINS-1:0] mode_q,
    input logic [PINS-1:0]   otype_q,
    input logic [PINS-1:0]   odata_q,
    input logic              lock_active,
    input logic [PINS-1:0]   lock_mask,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input logic [PINS-1:0]   pad_od,
    input logic [PINS-1:0]   pad_analog
);
    for (genvar p = 0; p < PINS; p++) begin : g_pin_chk
        assert_oe_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[p] |-> (mode_q[2*p +: 2] == 2'b01 || mode_q[2*p +: 2] == 2'b10));
        assert_analog_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            pad_analog[p] |-> !pad_oe[p]);
    end

    assert_od_never_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_od & pad_oe & pad_out) == '0);

    assert_set_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == AW'(6))
        |=> ((odata_q & $past(wr_low)) == $past(wr_low)));

    assert_locked_type_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_active && req_valid && req_write && req_addr == AW'(1))
        |=> (((otype_q ^ $past(otype_q)) & lock_mask) == '0));

    assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |=> (lock_active && $stable(lock_mask)));
endmodule

bind gpio_lock_port gpio_lock_port_chk #(.PINS(PINS), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .wr_low      (req_wdata[PINS-1:0]),
    .mode_q      (mode_w),
    .otype_q     (otype_w),
    .odata_q     (odata_w),
    .lock_active (lock_active),
    .lock_mask   (lock_mask),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_od      (pad_od),
    .pad_analog  (pad_analog)
);

// File: tb/gpio_lock_port_tb.sv
`timescale 1ns/1ps
module gpio_lock_port_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic [15:0] pad_in = '0, alt_drive_in = '0;
    logic [15:0] pad_out, pad_oe, pad_od, pad_analog;
    logic [31:0] pad_pull, pad_speed;
    logic [63:0] alt_sel;

    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    gpio_lock_port u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .pad_in(pad_in), .alt_drive_in(alt_drive_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_od(pad_od), .pad_pull(pad_pull),
        .pad_speed(pad_speed), .pad_analog(pad_analog), .alt_sel(alt_sel)
    );

    // behavioural reference state
    logic [31:0] m_mode, m_speed, m_pull, m_aflo, m_afhi;
    logic [15:0] m_otype, m_odata, m_s1, m_s2, m_lock, m_seen;
    int          m_step;
    bit          m_active;

    function automatic bit locked(int p);
        return m_active && m_lock[p];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_speed = 0; m_pull = 0; m_aflo = 0; m_afhi = 0;
            m_otype = 0; m_odata = 0; m_s1 = 0; m_s2 = 0; m_lock = 0; m_seen = 0;
            m_step = 0; m_active = 0;
        end else begin
            m_s2 = m_s1;
            m_s1 = pad_in;
            if (req_valid && req_write) begin
                for (int p = 0; p < 16; p++) begin
                    if (!locked(p)) begin
                        if (req_addr == 0) m_mode[2*p +: 2]  = req_wdata[2*p +: 2];
                        if (req_addr == 1) m_otype[p]        = req_wdata[p];
                        if (req_addr == 2) m_speed[2*p +: 2] = req_wdata[2*p +: 2];
                        if (req_addr == 3) m_pull[2*p +: 2]  = req_wdata[2*p +: 2];
                        if (req_addr == 8 && p < 8)  m_aflo[4*p +: 4]     = req_wdata[4*p +: 4];
                        if (req_addr == 9 && p >= 8) m_afhi[4*(p-8) +: 4] = req_wdata[4*(p-8) +: 4];
                    end
                    if (req_addr == 6) begin
                        if (req_wdata[p+16]) m_odata[p] = 1'b0;
                        if (req_wdata[p])    m_odata[p] = 1'b1;
                    end
                end
                if (req_addr == 5) m_odata = req_wdata[15:0];
                if (req_addr == 7 && !m_active) begin
                    if (m_step == 0) begin
                        if (req_wdata[16]) begin m_step = 1; m_seen = req_wdata[15:0]; end
                    end else if (m_step == 1)
                        m_step = (!req_wdata[16] && req_wdata[15:0] == m_seen) ? 2 : 0;
                    else if (m_step == 2)
                        m_step = (req_wdata[16] && req_wdata[15:0] == m_seen) ? 3 : 0;
                    else
                        m_step = 0;
                end
            end else if (req_valid && req_addr == 7 && !m_active && m_step == 3) begin
                m_active = 1; m_lock = m_seen; m_step = 0;
            end
        end
    end

    function automatic logic [31:0] exp_read(logic [3:0] a);
        logic [15:0] an;
        for (int p = 0; p < 16; p++) an[p] = (m_mode[2*p +: 2] == 2'b11);
        case (a)
            0: return m_mode;
            1: return {16'h0, m_otype};
            2: return m_speed;
            3: return m_pull;
            4: return {16'h0, m_s2 & ~an};
            5: return {16'h0, m_odata};
            7: return {15'h0, m_active, m_active ? m_lock : 16'h0};
            8: return m_aflo;
            9: return m_afhi;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison of pad outputs, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [15:0] e_out, e_oe, e_od, e_an;
            logic [31:0] e_spd;
            for (int p = 0; p < 16; p++) begin
                logic [1:0] md;
                logic drv, val;
                md  = m_mode[2*p +: 2];
                drv = (md == 2'b01) || (md == 2'b10);
                val = (md == 2'b10) ? alt_drive_in[p] : m_odata[p];
                e_out[p] = drv & val;
                e_oe[p]  = drv & (!m_otype[p] || !val);
                e_od[p]  = drv & m_otype[p];
                e_an[p]  = (md == 2'b11);
                e_spd[2*p +: 2] = drv ? m_speed[2*p +: 2] : 2'b00;
            end
            check("R2 pad_oe", 64'(pad_oe), 64'(e_oe));
            check("R2 pad_analog", 64'(pad_analog), 64'(e_an));
            check("R3 pad_out", 64'(pad_out), 64'(e_out));
            check("R4 pad_od", 64'(pad_od), 64'(e_od));
            check("R4 pad_speed", 64'(pad_speed), 64'(e_spd));
            check("R5 alt_sel", alt_sel, {m_afhi, m_aflo});
            check("R1 pad_pull", 64'(pad_pull), 64'(m_pull));
        end
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk); #2;
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(logic [3:0] a, string tag);
        @(negedge clk); #2;
        req_valid = 1; req_write = 0; req_addr = a; req_wdata = '0;
        #3;
        check(tag, 64'(rsp_rdata), 64'(exp_read(a)));
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); #2; rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); #2; rst_n = 1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1; total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        for (int a = 0; a < 10; a++) rd(4'(a), "R1 reset read");
        check("R1 pad_oe idle", 64'(pad_oe), 64'h0);

        // R2 R3 R4 R5: mixed mode configuration
        alt_drive_in = 16'h0231;
        wr(0, 32'h00187A55);
        wr(1, 32'h0000_0432);
        wr(2, 32'hFFFF_AAAA);
        wr(3, 32'h1234_5678);
        wr(8, 32'h89AB_CDEF);
        wr(9, 32'h7654_3210);
        wr(5, 32'h0000_00F5);
        for (int a = 0; a < 10; a++) rd(4'(a), "R2 readback");
        alt_drive_in = 16'h0010;
        repeat (2) @(posedge clk);

        // R6: set/clear including collisions
        wr(6, 32'h0003_0000);
        rd(5, "R6 clear");
        wr(6, 32'h0104_0104);
        rd(5, "R6 set wins");
        wr(6, 32'h0000_0000);
        rd(5, "R6 zeros no effect");
        rd(6, "R6 reads zero");

        // R7: synchronized inputs, analog pin masked
        pad_in = 16'hFFFF;
        rd(4, "R7 one edge");
        rd(4, "R7 two edges");
        rd(4, "R7 settled");
        pad_in = 16'h5AC3;
        repeat (3) @(posedge clk);
        rd(4, "R7 pattern");

        // R9: aborted sequences
        wr(7, 32'h0001_00F0);
        wr(7, 32'h0000_00F1);
        wr(7, 32'h0001_00F0);
        rd(7, "R9 mask change aborts");
        wr(7, 32'h0001_00F0);
        wr(7, 32'h0001_00F0);
        wr(7, 32'h0001_00F0);
        rd(7, "R9 wrong key aborts");
        wr(7, 32'h0001_00F0);
        wr(7, 32'h0000_00F0);
        wr(7, 32'h0001_00F0);
        wr(7, 32'h0001_00F0);
        rd(7, "R9 extra write aborts");
        wr(0, 32'h00187A55);
        rd(0, "R9 config still open");

        // R8: full sequence on pins 4..7 and 9
        wr(7, 32'h0001_02F0);
        wr(7, 32'h0000_02F0);
        wr(7, 32'h0001_02F0);
        rd(7, "R8 confirming read");
        rd(7, "R8 armed");

        // R10: locked pins hold, others follow
        wr(0, 32'hFFFF_FFFF);
        wr(1, 32'h0000_FFFF);
        wr(2, 32'h0000_0000);
        wr(3, 32'h0000_0000);
        wr(8, 32'h0000_0000);
        wr(9, 32'hFFFF_FFFF);
        for (int a = 0; a < 10; a++) rd(4'(a), "R10 locked fields");
        wr(5, 32'h0000_FFFF);
        wr(6, 32'h00F0_0000);
        rd(5, "R10 output data open");

        // R11: lock ignores further key writes
        wr(7, 32'h0001_0001);
        wr(7, 32'h0000_0001);
        wr(7, 32'h0001_0001);
        rd(7, "R11 confirm ignored");
        rd(7, "R11 still armed");

        // R1 R11: reset releases the lock
        do_reset();
        rd(7, "R1 lock cleared");
        wr(0, 32'h0000_0055);
        rd(0, "R1 config open after reset");
        repeat (3) @(posedge clk);

        done = 1;
        @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule